// File: doc/BRIEF.md
# Open-Circuit Fault Confirmation Controller

This block decides whether missing shoot-through notches on an impedance-source inverter's leg voltage come from a real open-circuit switch fault or from a passing disturbance. Once per half switching period the capture logic hands it one sample. A sample holds the number of falling edges seen on the digitised leg voltage, the captured edge timestamps and the expected edge times. When the count is below the nominal three, the sample is short, which means one leg did not produce its shoot-through notch.

Confirmation has two steps. A run of consecutive short samples raises a provisional `suspect` flag. The next window of samples is then buffered, each record tagged as short or full. A majority vote over that window either sets a sticky `confirmed` flag and pulses `id_start` for the downstream leg identifier, or drops the suspicion and goes back to watching. The run length, the window length and the vote threshold are parameters. Raising them trades detection speed for fewer false alarms.

Top module: `fc_confirm_ctrl`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `suspect`, `confirmed` and `id_start` are 0, and all `rec_valid`, `rec_faulty`, `rec_cap` and `rec_exp` bits are 0.
- R2: A sample (a cycle with `cyc_valid` high) is short when `edge_cnt` < NOM_EDGES (3). A count of 3 or more is healthy.
- R3: While watching, `suspect` rises on the clock edge that takes the third consecutive short sample (RUN_LEN = 3).
- R4: While watching, a healthy sample restarts the consecutive count from zero. Cycles with `cyc_valid` low change neither the count nor any output.
- R5: After `suspect` rises, the next WIN_LEN (5) samples are stored in arrival order. Record i uses `rec_valid[i]`, `rec_faulty[i]` (1 = short), `rec_cap[i*48 +: 48]` and `rec_exp[i*48 +: 48]`.
- R6: If at least VOTE (3) of the window's samples are short, `confirmed` rises on the edge that takes the last window sample. `suspect` stays high while `confirmed` is high.
- R7: If fewer than VOTE window samples are short, `suspect` falls on the edge that takes the last window sample. A fresh run of three short samples is then needed to raise it again.
- R8: Once `confirmed` is set, it and the stored records ignore further samples. A cycle with `confirm_clr` high clears both flags and all records and returns to watching.
- R9: The records are cleared on the edge where `suspect` rises. After a failed vote they stay readable until that edge.
- R10: `id_start` is high for exactly the one cycle in which `confirmed` first reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| confirm_clr | input | 1 | Clears flags and records, returns to watching |
| cyc_valid | input | 1 | One pulse per half switching period with a new sample |
| edge_cnt | input | 3 | Falling edges counted in the half period |
| cap_times | input | 48 | Three captured edge timestamps, 16 bits each |
| exp_times | input | 48 | Three expected edge times, 16 bits each |
| suspect | output | 1 | Provisional fault flag |
| confirmed | output | 1 | Sticky confirmed-fault flag |
| id_start | output | 1 | One-cycle start pulse for the leg identifier |
| rec_valid | output | 5 | Record slot holds a sample |
| rec_faulty | output | 5 | Record slot sample was short |
| rec_cap | output | 240 | Stored capture timestamps, slot i at bits i*48 |
| rec_exp | output | 240 | Stored expected times, slot i at bits i*48 |

## Verification
The checker watches several rules on every cycle. It checks that the start pulse occurs only together with the confirmed flag and lasts a single cycle, that the confirmed flag implies the suspect flag and stays set with frozen records until cleared, that idle cycles leave the flags and records untouched, that a clear empties everything, and that a new window always opens with empty records. Some behaviour can only be shown by the bench's scenarios, which track a behavioural model. These are the short-count boundary at exactly three edges, the run reset by a healthy sample, the vote outcome at exactly three of five, the order and content of the stored records, and the need for a fresh run after a failed vote.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_VOTE  = 2'd1,
        ST_HELD  = 2'd2
    } fc_state_e;

    // A sample is short when fewer edges than nominal were seen
    function automatic logic is_short(input int unsigned cnt, input int unsigned nominal);
        return cnt < nominal;
    endfunction

endpackage

// File: rtl/fc_run_counter.sv
module fc_run_counter #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step_en,
    input  logic short_smp,
    output logic hit
);
    localparam int RW = $clog2(RUN_LEN + 1);

    logic [RW-1:0] run_q;

    assign hit = step_en && short_smp && (run_q == RW'(RUN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q <= '0;
        end else if (step_en) begin
            if (!short_smp || hit) run_q <= '0;
            else                   run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/fc_window_vote.sv
module fc_window_vote #(
    parameter int WIN_LEN = 5,
    parameter int VOTE    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       step_en,
    input  logic                       short_smp,
    output logic [$clog2(WIN_LEN)-1:0] slot,
    output logic                       last,
    output logic                       pass
);
    localparam int IW = $clog2(WIN_LEN);
    localparam int VW = $clog2(WIN_LEN + 1);

    logic [IW-1:0] idx_q;
    logic [VW-1:0] votes_q;

    assign slot = idx_q;
    assign last = step_en && (idx_q == IW'(WIN_LEN - 1));
    assign pass = (int'(votes_q) + int'(short_smp)) >= VOTE;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q   <= '0;
            votes_q <= '0;
        end else if (step_en) begin
            idx_q   <= idx_q + 1'b1;
            votes_q <= votes_q + VW'(short_smp);
        end
    end
endmodule

// File: rtl/fc_record_bank.sv
module fc_record_bank #(
    parameter int WIN_LEN = 5,
    parameter int SW      = 48
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       wr_en,
    input  logic [$clog2(WIN_LEN)-1:0] wr_slot,
    input  logic                       wr_short,
    input  logic [SW-1:0]              wr_cap,
    input  logic [SW-1:0]              wr_exp,
    output logic [WIN_LEN-1:0]         rec_valid,
    output logic [WIN_LEN-1:0]         rec_faulty,
    output logic [WIN_LEN*SW-1:0]      rec_cap,
    output logic [WIN_LEN*SW-1:0]      rec_exp
);
    localparam int IW = $clog2(WIN_LEN);

    for (genvar s = 0; s < WIN_LEN; s++) begin : g_slot
        logic          v_q;
        logic          f_q;
        logic [SW-1:0] c_q;
        logic [SW-1:0] e_q;

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                v_q <= 1'b0;
                f_q <= 1'b0;
                c_q <= '0;
                e_q <= '0;
            end else if (wr_en && wr_slot == IW'(s)) begin
                v_q <= 1'b1;
                f_q <= wr_short;
                c_q <= wr_cap;
                e_q <= wr_exp;
            end
        end

        assign rec_valid[s]            = v_q;
        assign rec_faulty[s]           = f_q;
        assign rec_cap[s*SW +: SW]     = c_q;
        assign rec_exp[s*SW +: SW]     = e_q;
    end
endmodule

// File: rtl/fc_confirm_ctrl.sv
module fc_confirm_ctrl
    import fc_pkg::*;
#(
    parameter int NOM_EDGES = 3,
    parameter int TW        = 16,
    parameter int CNT_W     = 3,
    parameter int RUN_LEN   = 3,
    parameter int WIN_LEN   = 5,
    parameter int VOTE      = 3,
    localparam int REC_W    = NOM_EDGES * TW,
    localparam int BANK_W   = WIN_LEN * REC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               confirm_clr,
    input  logic               cyc_valid,
    input  logic [CNT_W-1:0]   edge_cnt,
    input  logic [REC_W-1:0]   cap_times,
    input  logic [REC_W-1:0]   exp_times,
    output logic               suspect,
    output logic               confirmed,
    output logic               id_start,
    output logic [WIN_LEN-1:0] rec_valid,
    output logic [WIN_LEN-1:0] rec_faulty,
    output logic [BANK_W-1:0]  rec_cap,
    output logic [BANK_W-1:0]  rec_exp
);
    localparam int IW = $clog2(WIN_LEN);

    fc_state_e     state_q;
    logic          suspect_q, confirmed_q, start_q;
    logic          smp_short;
    logic          run_step, run_hit;
    logic          win_step, win_last, win_pass;
    logic [IW-1:0] win_slot;
    logic          bank_clear;

    assign smp_short  = is_short(int'(edge_cnt), NOM_EDGES);
    assign run_step   = cyc_valid && (state_q == ST_WATCH);
    assign win_step   = cyc_valid && (state_q == ST_VOTE);
    assign bank_clear = confirm_clr || run_hit;

    fc_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk       (clk),
        .rst       (rst),
        .clear     (confirm_clr || state_q != ST_WATCH),
        .step_en   (run_step),
        .short_smp (smp_short),
        .hit       (run_hit)
    );

    fc_window_vote #(.WIN_LEN(WIN_LEN), .VOTE(VOTE)) u_vote (
        .clk       (clk),
        .rst       (rst),
        .clear     (confirm_clr || state_q != ST_VOTE),
        .step_en   (win_step),
        .short_smp (smp_short),
        .slot      (win_slot),
        .last      (win_last),
        .pass      (win_pass)
    );

    fc_record_bank #(.WIN_LEN(WIN_LEN), .SW(REC_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .clear      (bank_clear),
        .wr_en      (win_step),
        .wr_slot    (win_slot),
        .wr_short   (smp_short),
        .wr_cap     (cap_times),
        .wr_exp     (exp_times),
        .rec_valid  (rec_valid),
        .rec_faulty (rec_faulty),
        .rec_cap    (rec_cap),
        .rec_exp    (rec_exp)
    );

    always_ff @(posedge clk) begin
        if (rst || confirm_clr) begin
            state_q     <= ST_WATCH;
            suspect_q   <= 1'b0;
            confirmed_q <= 1'b0;
            start_q     <= 1'b0;
        end else begin
            start_q <= 1'b0;
            unique case (state_q)
                ST_WATCH: begin
                    if (run_hit) begin
                        suspect_q <= 1'b1;
                        state_q   <= ST_VOTE;
                    end
                end
                ST_VOTE: begin
                    if (win_last) begin
                        if (win_pass) begin
                            confirmed_q <= 1'b1;
                            start_q     <= 1'b1;
                            state_q     <= ST_HELD;
                        end else begin
                            suspect_q <= 1'b0;
                            state_q   <= ST_WATCH;
                        end
                    end
                end
                ST_HELD: ;
                default: state_q <= ST_WATCH;
            endcase
        end
    end

    assign suspect   = suspect_q;
    assign confirmed = confirmed_q;
    assign id_start  = start_q;
endmodule

// File: rtl/fc_confirm_chk.sv
module fc_confirm_chk #(
    parameter int WIN_LEN = 5,
    parameter int BANK_W  = 240
) (
    input logic               clk,
    input logic               rst,
    input logic               confirm_clr,
    input logic               cyc_valid,
    input logic               suspect,
    input logic               confirmed,
    input logic               id_start,
    input logic [WIN_LEN-1:0] rec_valid,
    input logic [BANK_W-1:0]  rec_cap
);
    p_start_needs_conf_r10: assert property (@(posedge clk) disable iff (rst)
        id_start |-> confirmed);

    p_start_single_r10: assert property (@(posedge clk) disable iff (rst)
        id_start |=> !id_start);

    p_rise_starts_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(confirmed) |-> id_start);

    p_conf_keeps_suspect_r6: assert property (@(posedge clk) disable iff (rst)
        confirmed |-> suspect);

    p_conf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        confirmed && !confirm_clr |=> confirmed && $stable(rec_valid) && $stable(rec_cap));

    p_clear_all_r8: assert property (@(posedge clk) disable iff (rst)
        confirm_clr |=> !suspect && !confirmed && rec_valid == '0);

    p_idle_no_change_r4: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid && !confirm_clr |=> $stable(suspect) && $stable(confirmed) && $stable(rec_valid));

    p_window_opens_empty_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(suspect) |-> rec_valid == '0);
endmodule

bind fc_confirm_ctrl fc_confirm_chk #(.WIN_LEN(WIN_LEN), .BANK_W(BANK_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .confirm_clr (confirm_clr),
    .cyc_valid   (cyc_valid),
    .suspect     (suspect),
    .confirmed   (confirmed),
    .id_start    (id_start),
    .rec_valid   (rec_valid),
    .rec_cap     (rec_cap)
);

// File: tb/fc_confirm_ctrl_tb.sv
module fc_confirm_ctrl_tb;
    localparam int SW = 48;
    localparam int NW = 5;

    logic            clk = 1'b0;
    logic            b_rst = 1'b1, b_clr = 1'b0, b_valid = 1'b0;
    logic [2:0]      b_cnt = '0;
    logic [SW-1:0]   b_cap = '0, b_exp = '0;
    logic            suspect, confirmed, id_start;
    logic [NW-1:0]   rec_valid, rec_faulty;
    logic [NW*SW-1:0] rec_cap, rec_exp;

    always #10 clk = ~clk;

    fc_confirm_ctrl u_dut (
        .clk(clk), .rst(b_rst), .confirm_clr(b_clr), .cyc_valid(b_valid),
        .edge_cnt(b_cnt), .cap_times(b_cap), .exp_times(b_exp),
        .suspect(suspect), .confirmed(confirmed), .id_start(id_start),
        .rec_valid(rec_valid), .rec_faulty(rec_faulty),
        .rec_cap(rec_cap), .rec_exp(rec_exp)
    );

    int checks = 0, errors = 0;
    int m_state = 0, m_run = 0;
    bit m_sus = 0, m_conf = 0, m_start = 0;
    bit q_f[$];
    logic [SW-1:0] q_c[$], q_e[$];
    int tick = 0;
    int unsigned lcg = 32'h1234_5678;

    task automatic chk(input string tag, input logic [NW*SW-1:0] act, input logic [NW*SW-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic model_clear();
        m_state = 0; m_run = 0; m_sus = 0; m_conf = 0;
        q_f.delete(); q_c.delete(); q_e.delete();
    endtask

    task automatic model_step();
        bit f;
        int nf;
        if (b_rst) begin
            model_clear(); m_start = 0;
        end else begin
            m_start = 0;
            if (b_clr) model_clear();
            else if (b_valid) begin
                f = (b_cnt < 3);
                if (m_state == 0) begin
                    if (f) begin
                        m_run++;
                        if (m_run == 3) begin
                            m_sus = 1; m_state = 1; m_run = 0;
                            q_f.delete(); q_c.delete(); q_e.delete();
                        end
                    end else m_run = 0;
                end else if (m_state == 1) begin
                    q_f.push_back(f); q_c.push_back(b_cap); q_e.push_back(b_exp);
                    if (q_f.size() == 5) begin
                        nf = 0;
                        foreach (q_f[i]) nf += int'(q_f[i]);
                        if (nf >= 3) begin m_conf = 1; m_start = 1; m_state = 2; end
                        else begin m_sus = 0; m_state = 0; end
                    end
                end
            end
        end
    endtask

    task automatic compare_all();
        logic [NW-1:0] ev, ef;
        logic [NW*SW-1:0] ec, ee;
        ev = '0; ef = '0; ec = '0; ee = '0;
        for (int i = 0; i < q_f.size(); i++) begin
            ev[i] = 1'b1; ef[i] = q_f[i];
            ec[i*SW +: SW] = q_c[i]; ee[i*SW +: SW] = q_e[i];
        end
        chk("R3 suspect", suspect, m_sus);
        chk("R6 confirmed", confirmed, m_conf);
        chk("R10 id_start", id_start, m_start);
        chk("R5 rec_valid", rec_valid, ev);
        chk("R5 rec_faulty", rec_faulty, ef);
        chk("R5 rec_cap", rec_cap, ec);
        chk("R5 rec_exp", rec_exp, ee);
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit v, input int c, input bit clr = 1'b0);
        tick++;
        b_valid = v; b_cnt = 3'(c); b_clr = clr;
        b_cap = {16'(tick * 7), 16'(tick * 5 + 1), 16'(tick * 3 + 2)};
        b_exp = {16'(tick + 100), 16'(tick + 200), 16'(tick + 300)};
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(0, 0); cyc(0, 0);
        b_rst = 1'b0;
        // R1: reset state
        chk("R1 reset suspect", suspect, 0);
        chk("R1 reset confirmed", confirmed, 0);
        chk("R1 reset records", rec_valid, 0);

        // R2 / R4: count of 3 is healthy and breaks the run
        cyc(1, 2); cyc(1, 2); cyc(1, 3); cyc(1, 2); cyc(1, 1); cyc(1, 4);
        chk("R4 run broken by healthy", suspect, 0);
        chk("R2 count three is healthy", suspect, 0);

        // R4: idle cycles between short samples keep the run
        cyc(1, 0); cyc(0, 4); cyc(1, 2); cyc(0, 4); cyc(0, 0);
        chk("R4 idle no effect", suspect, 0);
        cyc(1, 2);
        chk("R3 suspect after third short", suspect, 1);
        chk("R9 window opens empty", rec_valid, 0);

        // R7: window with two short -> drop
        cyc(1, 2); cyc(1, 3); cyc(0, 0); cyc(1, 4); cyc(1, 1); cyc(1, 3);
        chk("R7 suspect dropped", suspect, 0);
        chk("R9 records kept after failed vote", rec_valid, 5'b11111);
        cyc(1, 0); cyc(1, 0);
        chk("R7 fresh run needed", suspect, 0);
        cyc(1, 0);
        chk("R7 suspect again after fresh run", suspect, 1);

        // R6: exactly three of five short
        cyc(1, 2); cyc(1, 3); cyc(1, 2); cyc(1, 5); cyc(1, 1);
        chk("R6 confirmed set", confirmed, 1);
        chk("R10 start pulse", id_start, 1);
        cyc(0, 0);
        chk("R10 start single", id_start, 0);

        // R8: held state ignores samples
        cyc(1, 0); cyc(1, 4); cyc(1, 1);
        chk("R8 still confirmed", confirmed, 1);
        chk("R8 records frozen", rec_faulty, 5'b10101);
        cyc(0, 0, 1'b1);
        chk("R8 clear flags", confirmed, 0);
        chk("R8 clear records", rec_valid, 0);

        // all-short window and clear in mid-window
        cyc(1, 0); cyc(1, 0); cyc(1, 0);
        cyc(1, 0); cyc(1, 1); cyc(0, 0, 1'b1);
        chk("R8 clear mid-window", suspect, 0);
        cyc(1, 0); cyc(1, 1); cyc(1, 2);
        cyc(1, 0); cyc(1, 0); cyc(1, 0); cyc(1, 0); cyc(1, 0);
        chk("R6 all-short window", confirmed, 1);
        cyc(0, 0, 1'b1);

        // pseudo-random stream against the model
        for (int n = 0; n < 3000; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            cyc(lcg[20:18] != 3'd0, int'(lcg[10:8]) % 5, lcg[30:25] == 6'd0);
        end

        // R1: reset mid-operation
        cyc(1, 0); cyc(1, 0); cyc(1, 0);
        b_rst = 1'b1; cyc(1, 0); b_rst = 1'b0;
        chk("R1 reset again", suspect, 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule